// File: doc/BRIEF.md
# Carrier Offset Derotator

This block removes a residual carrier frequency offset from a complex baseband sample stream. It contains a numerically controlled oscillator: a signed frequency word is added into a phase register once per accepted sample. The top bits of that phase select one point of a sine wave. Sine and cosine both come from one quarter-wave table. Each incoming I/Q pair is then rotated by the conjugate of that phasor, so the I/Q pair spins back against the offset, and the result is rounded and clipped to the input width.

A frequency estimator elsewhere supplies the frequency word. The word may change at any time. The phase register can be cleared at the start of a burst. A result appears a fixed number of cycles after each input sample, and its valid flag travels alongside it.

Top module: `nco_freq_corrector`

## Requirements
- R1: During and right after reset, `outValid` is low and `outI`/`outQ` are zero.
- R2: Each sample accepted with `inValid` high yields exactly one result, with `outValid` high, 3 clock edges later. Results keep input order, and `outValid` is never high without a matching input.
- R3: The 24-bit phase register advances by the signed two's complement `freqWord` (modulo 2^24) on each accepted sample. A sample is rotated by the phase reached before its own increment.
- R4: A high `phaseReset` clears the phase register. A sample accepted in the same cycle is rotated with phase zero, and the register then holds `freqWord`.
- R5: The rotation angle index p is the top 8 bits of the phase register. The sine used is round(2047·sin(2π(p+0.5)/256)), with halves rounded away from zero.
- R6: Cosine is read from the same quarter-wave table at index (63 − p) mod 256. The two top bits of an index choose address mirroring (bit 6) and negation (bit 7), so all four quadrants give round(2047·cos(2π(p+0.5)/256)).
- R7: Results are I' = I·cos + Q·sin and Q' = Q·cos − I·sin. Each sum is rounded by adding 1024 and shifting right arithmetically by 11.
- R8: A rounded result above 2047 is clipped to 2047, and one below −2048 is clipped to −2048.
- R9: Cycles without `inValid` leave the phase unchanged, whatever `freqWord` holds. Between results, `outI`/`outQ` keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | 12 | In-phase input sample, signed |
| inQ | input | 12 | Quadrature input sample, signed |
| freqWord | input | 24 | Signed phase increment per sample |
| phaseReset | input | 1 | Clears the phase register |
| outValid | output | 1 | Result strobe |
| outI | output | 12 | Corrected in-phase sample, signed |
| outQ | output | 12 | Corrected quadrature sample, signed |

## Verification
Each accepted sample produces its result on the third rising edge after the edge that took it in. The phase used for that sample is the one settled before that first edge. The driver records, for every sample, the cycle count at which its result is due. It also records the expected I/Q, computed from its own phase model and floating-point trigonometry. The monitor samples on falling edges and pops one entry per high `outValid`. It compares the current cycle count with the recorded due cycle, so an early, late, missing or extra result is reported as well as a wrong value.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Per-stage load strobes handed from the control to the datapath.
  typedef struct packed {
    logic capture;  // take input sample and phasor
    logic mix;      // form the cross products
    logic finish;   // round, clip and present
  } nco_strobe_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int IDX_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      phaseReset,
  input  logic signed [PHASE_W-1:0] freqWord,
  output logic [IDX_W-1:0]          phaseIdx,
  output nco_strobe_t               strobe,
  output logic                      outValid
);
  logic [PHASE_W-1:0] phaseAcc;
  logic [PHASE_W-1:0] phaseNow;
  logic               mixPending;
  logic               finishPending;

  // A reset request takes effect for the sample presented in the same cycle.
  assign phaseNow = phaseReset ? '0 : phaseAcc;
  assign phaseIdx = phaseNow[PHASE_W-1 -: IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
    end else if (inValid) begin
      phaseAcc <= phaseNow + freqWord;
    end else begin
      phaseAcc <= phaseNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mixPending    <= 1'b0;
      finishPending <= 1'b0;
      outValid      <= 1'b0;
    end else begin
      mixPending    <= inValid;
      finishPending <= mixPending;
      outValid      <= finishPending;
    end
  end

  assign strobe.capture = inValid;
  assign strobe.mix     = mixPending;
  assign strobe.finish  = finishPending;
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int IDX_W  = 8,
  parameter int SINE_W = 12
) (
  input  logic [IDX_W-1:0]         phaseIdx,
  output logic signed [SINE_W-1:0] sinVal,
  output logic signed [SINE_W-1:0] cosVal
);
  localparam int  QTR_W = IDX_W - 2;
  localparam int  QTR_N = 1 << QTR_W;
  localparam real AMP   = real'((1 << (SINE_W - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;
  localparam logic [IDX_W-1:0] COS_OFS = IDX_W'(QTR_N - 1);

  function automatic logic [SINE_W-1:0] quarterPoint(input int k);
    real ang;
    ang = TWO_PI * (real'(k) + 0.5) / real'(4 * QTR_N);
    return SINE_W'($rtoi(AMP * $sin(ang) + 0.5));
  endfunction

  logic [SINE_W-1:0] qTable [QTR_N];

  for (genvar k = 0; k < QTR_N; k++) begin : g_tab
    localparam logic [SINE_W-1:0] POINT = quarterPoint(k);
    assign qTable[k] = POINT;
  end

  // Port 0 reads sine at p, port 1 reads sine at (quarter-1 - p), which is cosine.
  logic [IDX_W-1:0]         portIdx [2];
  logic signed [SINE_W-1:0] portVal [2];

  assign portIdx[0] = phaseIdx;
  assign portIdx[1] = COS_OFS - phaseIdx;

  for (genvar pp = 0; pp < 2; pp++) begin : g_port
    logic [QTR_W-1:0]  off;
    logic [SINE_W-1:0] mag;
    assign off = portIdx[pp][IDX_W-2] ? ~portIdx[pp][QTR_W-1:0] : portIdx[pp][QTR_W-1:0];
    assign mag = qTable[off];
    assign portVal[pp] = portIdx[pp][IDX_W-1] ? -mag : mag;
  end

  assign sinVal = portVal[0];
  assign cosVal = portVal[1];
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SINE_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  nco_strobe_t              strobe,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic signed [SINE_W-1:0] sinVal,
  input  logic signed [SINE_W-1:0] cosVal,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  localparam int SUM_W = DATA_W + SINE_W + 1;
  localparam int FRAC  = SINE_W - 1;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1 << (FRAC - 1));
  localparam logic signed [SUM_W-1:0] TOP  = SUM_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] BOT  = ~TOP;

  logic signed [DATA_W-1:0] smpI, smpQ;
  logic signed [SINE_W-1:0] rotS, rotC;
  logic signed [SUM_W-1:0]  sumI, sumQ;

  function automatic logic signed [DATA_W-1:0] shrink(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] r;
    r = (v + HALF) >>> FRAC;
    if (r > TOP)      return DATA_W'(TOP);
    else if (r < BOT) return DATA_W'(BOT);
    else              return DATA_W'(r);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpI <= '0;
      smpQ <= '0;
      rotS <= '0;
      rotC <= '0;
    end else if (strobe.capture) begin
      smpI <= inI;
      smpQ <= inQ;
      rotS <= sinVal;
      rotC <= cosVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumI <= '0;
      sumQ <= '0;
    end else if (strobe.mix) begin
      sumI <= SUM_W'(smpI) * SUM_W'(rotC) + SUM_W'(smpQ) * SUM_W'(rotS);
      sumQ <= SUM_W'(smpQ) * SUM_W'(rotC) - SUM_W'(smpI) * SUM_W'(rotS);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outI <= '0;
      outQ <= '0;
    end else if (strobe.finish) begin
      outI <= shrink(sumI);
      outQ <= shrink(sumQ);
    end
  end
endmodule

// File: rtl/nco_freq_corrector.sv
module nco_freq_corrector
  import nco_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int PHASE_W = 24,
  parameter int IDX_W   = 8,
  parameter int SINE_W  = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic signed [DATA_W-1:0]  inI,
  input  logic signed [DATA_W-1:0]  inQ,
  input  logic signed [PHASE_W-1:0] freqWord,
  input  logic                      phaseReset,
  output logic                      outValid,
  output logic signed [DATA_W-1:0]  outI,
  output logic signed [DATA_W-1:0]  outQ
);
  nco_strobe_t              strobe;
  logic [IDX_W-1:0]         phaseIdx;
  logic signed [SINE_W-1:0] sinVal, cosVal;

  nco_ctrl #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .phaseReset(phaseReset),
    .freqWord(freqWord), .phaseIdx(phaseIdx), .strobe(strobe), .outValid(outValid)
  );

  nco_sincos #(.IDX_W(IDX_W), .SINE_W(SINE_W)) u_sincos (
    .phaseIdx(phaseIdx), .sinVal(sinVal), .cosVal(cosVal)
  );

  nco_mixer #(.DATA_W(DATA_W), .SINE_W(SINE_W)) u_mixer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inI(inI), .inQ(inQ),
    .sinVal(sinVal), .cosVal(cosVal), .outI(outI), .outQ(outQ)
  );
endmodule

// File: rtl/nco_corr_checker.sv
module nco_corr_checker #(
  parameter int DATA_W = 12,
  parameter int IDX_W  = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     phaseReset,
  input logic [IDX_W-1:0]         phaseIdx,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outI,
  input logic signed [DATA_W-1:0] outQ
);
  logic [1:0] armCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               armCnt <= '0;
    else if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outI == '0 && outQ == '0));

  // R2
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 3));

  // R2
  in_yields_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt == 2'd3 && $past(inValid, 3)) |-> outValid);

  // R4
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseReset && !inValid) |=> (phaseIdx == '0));

  // R9
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !phaseReset) |=> (phaseReset || $stable(phaseIdx)));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outI) && $stable(outQ)));
endmodule

bind nco_freq_corrector nco_corr_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .phaseReset(phaseReset),
  .phaseIdx(phaseIdx), .outValid(outValid), .outI(outI), .outQ(outQ)
);

// File: tb/tb_nco_freq_corrector.sv
module tb_nco_freq_corrector;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [11:0] inI = '0, inQ = '0;
  logic signed [23:0] freqWord = '0;
  logic phaseReset = 1'b0;
  logic outValid;
  logic signed [11:0] outI, outQ;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  longint modelAcc = 0;

  int    dueQ[$];
  int    expIQ[$];
  int    expQQ[$];
  string tagQ[$];

  nco_freq_corrector dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .freqWord(freqWord), .phaseReset(phaseReset),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int clip(input longint v);
    longint r;
    r = (v + 1024) >>> 11;
    if (r > 2047) return 2047;
    if (r < -2048) return -2048;
    return int'(r);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Driver: presents one sample for one edge and records what must come back.
  task automatic sendSample(input int i, input int q, input int f, input bit pr, input string tag);
    longint eff;
    int p, s, c;
    real ang;
    eff = pr ? 0 : modelAcc;
    p = int'((eff >> 16) & 255);
    ang = 6.283185307179586 * (real'(p) + 0.5) / 256.0;
    s = rnd(2047.0 * $sin(ang));
    c = rnd(2047.0 * $cos(ang));
    dueQ.push_back(cyc + 3);
    expIQ.push_back(clip(longint'(i) * c + longint'(q) * s));
    expQQ.push_back(clip(longint'(q) * c - longint'(i) * s));
    tagQ.push_back(tag);
    modelAcc = (eff + longint'(f)) & 64'hFFFFFF;
    inValid = 1'b1; inI = 12'(i); inQ = 12'(q);
    freqWord = 24'(f); phaseReset = pr;
    @(negedge clk);
    inValid = 1'b0; phaseReset = 1'b0;
  endtask

  task automatic idle(input int n, input int f, input bit pr);
    for (int k = 0; k < n; k++) begin
      inValid = 1'b0; freqWord = 24'(f); phaseReset = pr;
      inI = 12'(k * 13); inQ = -12'(k * 7);
      if (pr) modelAcc = 0;
      @(negedge clk);
    end
    phaseReset = 1'b0;
  endtask

  // Monitor: compares each result against the oldest expectation.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (dueQ.size() == 0) begin
        fails++; checks++;
        $display("FAIL R2: unexpected result I=%0d Q=%0d expected none", outI, outQ);
      end else begin
        automatic int    due = dueQ.pop_front();
        automatic int    ei  = expIQ.pop_front();
        automatic int    eq  = expQQ.pop_front();
        automatic string tg  = tagQ.pop_front();
        check("R2 latency", cyc, due);
        check({tg, " I"}, int'(outI), ei);
        check({tg, " Q"}, int'(outQ), eq);
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(outValid), 0);
    check("R1 I in reset", int'(outI), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(outValid), 0);
    check("R1 Q after reset", int'(outQ), 0);

    // R7: plain rotation at phase index 0
    sendSample(1000, 0, 0, 1'b1, "R7");
    sendSample(0, 1000, 0, 1'b0, "R7");
    sendSample(-700, 300, 0, 1'b0, "R7");
    sendSample(2047, -2048, 0, 1'b0, "R7");
    idle(5, 0, 1'b0);

    // R5 R6: one index per sample across all quadrants
    sendSample(1500, -900, 1 << 16, 1'b1, "R5");
    for (int k = 1; k < 256; k++)
      sendSample(((k * 37) % 4000) - 2000, ((k * 91) % 4000) - 2000, 1 << 16, 1'b0, "R6");
    idle(5, 0, 1'b0);

    // R3: negative frequency word, wrapping, with gaps
    for (int k = 0; k < 60; k++) begin
      sendSample(1800 - k * 50, k * 40 - 1200, -(3 << 16) + 12345, 1'b0, "R3");
      if (k % 7 == 3) idle(2, -(3 << 16) + 12345, 1'b0);
    end
    for (int k = 0; k < 40; k++)
      sendSample(900, 1100, 24'h7FFFFF, 1'b0, "R3 wrap");
    idle(5, 0, 1'b0);

    // R9: idle cycles with a large word must not move the phase
    sendSample(1234, -567, 5 << 16, 1'b0, "R9");
    idle(10, 24'h3ABCDE, 1'b0);
    sendSample(1234, -567, 5 << 16, 1'b0, "R9");
    idle(4, -1, 1'b0);
    sendSample(-1500, 800, 0, 1'b0, "R9");
    idle(5, 0, 1'b0);

    // R4: reset alone, then reset together with a sample
    sendSample(700, 700, 77 << 16, 1'b0, "R4");
    sendSample(700, 700, 77 << 16, 1'b0, "R4");
    idle(1, 0, 1'b1);
    sendSample(1600, -400, 9 << 16, 1'b0, "R4 after clear");
    sendSample(1600, -400, 9 << 16, 1'b0, "R4");
    sendSample(-300, 1900, 20 << 16, 1'b1, "R4 same cycle");
    sendSample(-300, 1900, 20 << 16, 1'b0, "R4");
    idle(5, 0, 1'b0);

    // R8: near 45 degrees full-scale inputs must clip
    sendSample(-2048, -2048, 31 << 16, 1'b1, "R8");
    for (int k = 0; k < 8; k++) begin
      sendSample(-2048, -2048, 31 << 16, 1'b0, "R8");
      sendSample(2047, 2047, 31 << 16, 1'b0, "R8");
      sendSample(2047, -2048, 31 << 16, 1'b0, "R8");
    end
    idle(8, 0, 1'b0);

    check("R2 all results seen", dueQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule